// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two unrelated clock domains. A producer pushes words on its own write clock, and a consumer pulls them on a separate read clock. Each side has a pair of enables that must both be high for a transfer to happen. The storage depth is a power of two, chosen by an address-width parameter, from 256 up to 8192 words.

The write pointer and the read pointer each carry one wrap bit. Each pointer crosses into the other domain as Gray code through a two-stage synchronizer. Each domain registers its own flags from its own pointer and the synchronized copy of the other pointer. The full and almost-full flags live on the write clock. The empty and almost-empty flags live on the read clock. All four flags are active-low. The almost thresholds come from two offset parameters.

Read data sits in an output register. An output enable either drives that register onto the data pins or releases the pins to high impedance.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wr_en_a` and `wr_en_b` are both high; with either one low, the FIFO contents and flags are unchanged.
- R2: A word is loaded into the output register on a rising read-clock edge only when `rd_en_a` and `rd_en_b` are both high and the FIFO is not empty; with either one low, the output register holds.
- R3: Words leave in the order they were written, with no loss or duplication.
- R4: `empty_n` is low exactly when the read side sees zero stored words, and it changes only on read-clock edges.
- R5: `full_n` is low exactly when 2^ADDR_W words are stored, and it changes only on write-clock edges; the stored count never exceeds 2^ADDR_W.
- R6: `almost_full_n` is low when the stored count is 2^ADDR_W - AF_OFS or more, and high at 2^ADDR_W - AF_OFS - 1 or fewer.
- R7: `almost_empty_n` is low when AE_OFS or fewer words are stored, and high at AE_OFS + 1 or more.
- R8: A write attempted while `full_n` is low is dropped. A read attempted while `empty_n` is low is dropped, and the output register keeps its last value. Neither pointer moves in either case.
- R9: With `rd_oe` low, `rd_q` is high impedance; toggling `rd_oe` changes neither the output register nor any flag.
- R10: While `rst_n` is low, both pointers and the output register clear; `empty_n` and `almost_empty_n` are low, and `full_n` and `almost_full_n` are high.
- R11: After a single write into an empty FIFO, `empty_n` rises no sooner than the second and no later than the third rising read-clock edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | 9 | Word to store |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Drives `rd_q` when high; releases it to high impedance when low |
| rd_q | output | 9 | Output register contents, three-state |
| full_n | output | 1 | Full flag, active low, write domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The bound checker watches pointer behaviour on every edge of each clock:
- A pointer stays put whenever one of its two enables is low.
- A pointer also stays put while its own flag shows full or empty.
- A qualified read advances the read pointer by exactly one.
- The write side never sees more than a full memory's worth of words.

Some behaviours need the bench's scenarios, because they depend on what was written earlier or on which edge a flag moves:
- Data order.
- Where each threshold flag switches.
- The first-word latency at the empty boundary.
- The high-impedance bus.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W = 9;
  localparam int PTR_MAX_W = 16;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [PTR_MAX_W-1:0] ptr_t;

  // binary to reflected Gray code
  function automatic ptr_t bin_to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary (zero-extended input)
  function automatic ptr_t gray_to_bin(input ptr_t g);
    ptr_t b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // fill level from two wrap-bit pointers; caller truncates to pointer width
  function automatic ptr_t ptr_diff(input ptr_t ahead, input ptr_t behind);
    return ahead - behind;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  dcf_pkg::word_t    wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output dcf_pkg::word_t    rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  dcf_pkg::word_t ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= ram[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int ADDR_W = 8,
  parameter int AF_OFS = 7
) (
  input  logic            wclk,
  input  logic            rst_n,
  input  logic            wen_a,
  input  logic            wen_b,
  input  logic [ADDR_W:0] rgray_s,
  output logic [ADDR_W:0] wptr_bin,
  output logic [ADDR_W:0] wgray,
  output logic            wr_go,
  output logic            full_n,
  output logic            afull_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_OFS);

  logic [PW-1:0] wnext, rbin_s, lvl;

  assign wr_go  = wen_a & wen_b & full_n;
  assign wnext  = wptr_bin + PW'(wr_go);
  assign rbin_s = PW'(dcf_pkg::gray_to_bin(dcf_pkg::PTR_MAX_W'(rgray_s)));
  assign lvl    = PW'(dcf_pkg::ptr_diff(dcf_pkg::PTR_MAX_W'(wnext),
                                        dcf_pkg::PTR_MAX_W'(rbin_s)));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin <= '0;
      wgray    <= '0;
      full_n   <= 1'b1;
      afull_n  <= 1'b1;
    end else begin
      wptr_bin <= wnext;
      wgray    <= PW'(dcf_pkg::bin_to_gray(dcf_pkg::PTR_MAX_W'(wnext)));
      full_n   <= (lvl != FULL_LVL);
      afull_n  <= (lvl < AF_LVL);
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int ADDR_W = 8,
  parameter int AE_OFS = 7
) (
  input  logic            rclk,
  input  logic            rst_n,
  input  logic            ren_a,
  input  logic            ren_b,
  input  logic [ADDR_W:0] wgray_s,
  output logic [ADDR_W:0] rptr_bin,
  output logic [ADDR_W:0] rgray,
  output logic            rd_go,
  output logic            empty_n,
  output logic            aempty_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] AE_LVL = PW'(AE_OFS);

  logic [PW-1:0] rnext, wbin_s, lvl;

  assign rd_go  = ren_a & ren_b & empty_n;
  assign rnext  = rptr_bin + PW'(rd_go);
  assign wbin_s = PW'(dcf_pkg::gray_to_bin(dcf_pkg::PTR_MAX_W'(wgray_s)));
  assign lvl    = PW'(dcf_pkg::ptr_diff(dcf_pkg::PTR_MAX_W'(wbin_s),
                                        dcf_pkg::PTR_MAX_W'(rnext)));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rptr_bin <= rnext;
      rgray    <= PW'(dcf_pkg::bin_to_gray(dcf_pkg::PTR_MAX_W'(rnext)));
      empty_n  <= (lvl != '0);
      aempty_n <= (lvl > AE_LVL);
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int ADDR_W = 8,
  parameter int AF_OFS = 7,
  parameter int AE_OFS = 7
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       wr_en_a,
  input  logic       wr_en_b,
  input  logic [8:0] wr_data,
  input  logic       rd_en_a,
  input  logic       rd_en_b,
  input  logic       rd_oe,
  output logic [8:0] rd_q,
  output logic       full_n,
  output logic       almost_full_n,
  output logic       empty_n,
  output logic       almost_empty_n
);
  localparam int PW = ADDR_W + 1;

  // named internal events, also used by the bound checker
  logic [PW-1:0]  wptr_bin, rptr_bin, wgray, rgray, wgray_s, rgray_s;
  logic           wr_go, rd_go;
  dcf_pkg::word_t q_reg;

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_OFS(AF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_a(wr_en_a), .wen_b(wr_en_b),
    .rgray_s(rgray_s), .wptr_bin(wptr_bin), .wgray(wgray),
    .wr_go(wr_go), .full_n(full_n), .afull_n(almost_full_n)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W), .AE_OFS(AE_OFS)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_a(rd_en_a), .ren_b(rd_en_b),
    .wgray_s(wgray_s), .rptr_bin(rptr_bin), .rgray(rgray),
    .rd_go(rd_go), .empty_n(empty_n), .aempty_n(almost_empty_n)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_mem #(.ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .we(wr_go), .waddr(wptr_bin[ADDR_W-1:0]), .wdata(wr_data),
    .re(rd_go), .raddr(rptr_bin[ADDR_W-1:0]), .rdata_q(q_reg)
  );

  assign rd_q = rd_oe ? q_reg : 9'bz;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int ADDR_W = 8
) (
  input logic            wclk,
  input logic            rclk,
  input logic            rst_n,
  input logic            wr_en_a,
  input logic            wr_en_b,
  input logic            rd_en_a,
  input logic            rd_en_b,
  input logic            full_n,
  input logic            empty_n,
  input logic [ADDR_W:0] wptr,
  input logic [ADDR_W:0] rptr,
  input logic [ADDR_W:0] rgray_s
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  logic [PW-1:0] w_view_lvl;
  assign w_view_lvl = wptr - PW'(dcf_pkg::gray_to_bin(dcf_pkg::PTR_MAX_W'(rgray_s)));

  // R1
  single_wen_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wr_en_a && wr_en_b) |=> $stable(wptr));

  // R2
  single_ren_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_en_a && rd_en_b) |=> $stable(rptr));

  // R2
  rd_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en_a && rd_en_b && empty_n) |=> (rptr == $past(rptr) + PW'(1)));

  // R8
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  // R8
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));

  // R5
  level_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    w_view_lvl <= DEPTH_V);
endmodule

bind dcf_fifo dcf_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .full_n(full_n), .empty_n(empty_n),
  .wptr(wptr_bin), .rptr(rptr_bin), .rgray_s(rgray_s)
);

// File: tb/dcf_fifo_bench.sv
module dcf_fifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AFO   = 3;
  localparam int AEO   = 2;
  localparam int NV    = 10;
  // {writes, reads, expected stored level afterwards}
  localparam int VEC [NV][3] = '{
    '{5, 0, 5}, '{0, 3, 2}, '{1, 0, 3}, '{9, 0, 12}, '{1, 0, 13},
    '{3, 0, 16}, '{2, 0, 16}, '{0, 16, 0}, '{0, 2, 0}, '{4, 4, 0}
  };

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0, rd_oe = 1;
  logic [8:0] wr_data = '0;
  wire  [8:0] rd_q;
  wire full_n, almost_full_n, empty_n, almost_empty_n;

  int n_chk = 0, n_bad = 0;
  logic [8:0] mq [$];
  logic [8:0] wd = 9'h101;
  logic [8:0] last_q = '0;

  always #4   wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  dcf_fifo #(.ADDR_W(AW), .AF_OFS(AFO), .AE_OFS(AEO)) u_dcf_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe), .rd_q(rd_q),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic push(input int n, input logic a, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en_a = a; wr_en_b = b; wr_data = wd;
      if (a && b && mq.size() < DEPTH) mq.push_back(wd);
      wd = wd + 9'd1;
    end
    @(negedge wclk);
    wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin
      logic [8:0] e;
      @(negedge rclk);
      rd_en_a = 1; rd_en_b = 1;
      @(negedge rclk);
      rd_en_a = 0; rd_en_b = 0;
      if (mq.size() > 0) begin
        e = mq.pop_front();
        chk("R3 read data", 16'(rd_q), 16'(e));
      end else begin
        e = last_q;
        chk("R8 empty read holds output", 16'(rd_q), 16'(e));
      end
      last_q = e;
    end
  endtask

  task automatic flags(input string tag, input int lvl);
    chk({tag, " R4 empty_n"},        16'(empty_n),        16'(lvl != 0));
    chk({tag, " R5 full_n"},         16'(full_n),         16'(lvl != DEPTH));
    chk({tag, " R6 almost_full_n"},  16'(almost_full_n),  16'(lvl < DEPTH - AFO));
    chk({tag, " R7 almost_empty_n"}, 16'(almost_empty_n), 16'(lvl > AEO));
  endtask

  task automatic do_reset();
    rst_n = 0;
    mq.delete();
    last_q = '0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    settle();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    do_reset();
    // R10 reset state
    flags("R10 reset", 0);
    chk("R10 output register cleared", 16'(rd_q), 16'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      push(VEC[v][0], 1'b1, 1'b1);
      settle();
      pop(VEC[v][1]);
      settle();
      flags($sformatf("vec%0d", v), VEC[v][2]);
    end

    // R1: a single write enable stores nothing
    push(2, 1'b1, 1'b0);
    push(2, 1'b0, 1'b1);
    settle();
    flags("R1 single write enable", 0);

    // R11: first-word latency at the empty boundary
    begin
      int k;
      @(negedge wclk);
      wr_en_a = 1; wr_en_b = 1; wr_data = wd; mq.push_back(wd); wd = wd + 9'd1;
      @(posedge wclk);
      #1 wr_en_a = 0; wr_en_b = 0;
      k = 0;
      for (int i = 1; i <= 6; i++) begin
        @(posedge rclk);
        #1;
        if (empty_n && k == 0) k = i;
      end
      chk("R11 empty_n not before edge 2", 16'(k >= 2), 16'h1);
      chk("R11 empty_n by edge 3", 16'(k <= 3 && k != 0), 16'h1);
    end

    // R2: a single read enable leaves the output register alone
    settle();
    @(negedge rclk); rd_en_a = 1; rd_en_b = 0;
    @(negedge rclk); rd_en_a = 0; rd_en_b = 1;
    @(negedge rclk); rd_en_b = 0;
    settle();
    chk("R2 single read enable holds output", 16'(rd_q), 16'(last_q));
    flags("R2 single read enable", 1);
    pop(1);
    settle();
    flags("R2 after read", 0);

    // R9: output enable releases the bus and disturbs nothing
    push(3, 1'b1, 1'b1);
    settle();
    pop(1);
    rd_oe = 0;
    @(negedge rclk);
    chk("R9 bus released", 16'(rd_q !== last_q), 16'h1);
    repeat (3) @(negedge rclk);
    rd_oe = 1;
    @(negedge rclk);
    chk("R9 register kept", 16'(rd_q), 16'(last_q));
    flags("R9 flags kept", 2);

    // R10: reset in mid-run
    push(14, 1'b1, 1'b1);
    settle();
    flags("R10 before reset", 16);
    do_reset();
    flags("R10 after mid-run reset", 0);
    chk("R10 output cleared again", 16'(rd_q), 16'h0);

    wrap_up();
  end
endmodule